// File: doc/BRIEF.md
# Cycle-Stealing Display DMA Bus Arbiter

This block shares one memory bus between a processor and two display fetch engines. One engine fetches playfield data and the other fetches player-missile data. When an engine raises its request, the arbiter asserts a halt signal to the processor in the next cycle and acknowledges the winning engine in that same cycle. In the cycle after that, the processor's bus drivers are switched off and the arbiter puts the captured fetch address on the memory bus. At the end of that stolen cycle the arbiter latches the memory data and hands it back to the engine with a single-cycle valid strobe. After a request starts, no processor action is needed.

When no engine is asking for the bus, the halt signal falls and the processor gets the bus back on the following cycle. A request that is held high, or requests that keep coming, steal one cycle after another while the halt signal stays high. Each acknowledge stands for exactly one read. If an engine keeps its request high after an acknowledge, it is asking for another read and must present its next address by then.

Top module: `dma_cycle_thief`

## Requirements
- R1: While reset is active (`rst_n` low) the block holds `halt`, both acknowledges and both valid strobes at 0 and `cpu_bus_en` at 1.
- R2: If either request is high at a rising clock edge, `halt` is 1 in the cycle that follows. In that same cycle exactly one acknowledge (`pm_ack` or `pf_ack`) is 1, marking the source granted at that edge.
- R3: If both requests are high at the same edge, the player-missile source wins: `pm_ack` is 1 and `pf_ack` is 0.
- R4: In the cycle after a `halt` cycle (the stolen cycle), `cpu_bus_en` is 0 and `mem_we` is 0. `mem_addr` then carries the address that the granted source presented at its grant edge.
- R5: In the cycle after a stolen cycle, the granted source's valid strobe (`pm_valid` or `pf_valid`) is 1 for that one cycle. `dma_rdata` then holds the value that `mem_rdata` had during the stolen cycle.
- R6: If neither request is high at an edge, `halt` is 0 in the next cycle and the processor owns the bus in the cycle after that. Owning the bus means `cpu_bus_en` is 1 and `mem_addr`, `mem_wdata` and `mem_we` follow `cpu_addr`, `cpu_wdata` and `cpu_we`.
- R7: Requests at consecutive edges steal consecutive cycles. `halt` stays at 1 with no gap, and each stolen cycle serves the grant made two edges before it, in grant order.
- R8: `cpu_rdata` always shows `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pm_req | input | 1 | Player-missile fetch request |
| pm_addr | input | AW | Player-missile fetch address, valid with `pm_req` |
| pm_ack | output | 1 | Player-missile request granted (halt cycle) |
| pm_valid | output | 1 | Player-missile read data valid strobe |
| pf_req | input | 1 | Playfield fetch request |
| pf_addr | input | AW | Playfield fetch address, valid with `pf_req` |
| pf_ack | output | 1 | Playfield request granted (halt cycle) |
| pf_valid | output | 1 | Playfield read data valid strobe |
| dma_rdata | output | DW | Read data returned to the fetch engines |
| halt | output | 1 | Halt to the processor, one cycle ahead of each stolen cycle |
| cpu_bus_en | output | 1 | Processor bus drivers enabled; 0 means tri-stated |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_we | input | 1 | Processor write enable |
| cpu_rdata | output | DW | Read data to the processor |
| mem_addr | output | AW | Memory address bus |
| mem_wdata | output | DW | Memory write data bus |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data bus |

## Verification
When requests arrive back to back, one cycle can carry three things at once. It holds the grant acknowledge for the newest request and the stolen bus cycle for the one before it. It also holds the data return strobe for the request before that, and each of the three may belong to a different source. The bench provokes this by keeping requests high for long random runs and switching between sources, and it mixes in directed cases with simultaneous requests. A bench model keeps a three-deep history of grant decisions built only from the requirements. Against that history it checks every output each cycle, including which strobe fires and which address and data belong to which grant.

// File: rtl/dma_cycle_thief.sv
module dma_cycle_thief #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pm_req,
  input  logic [AW-1:0] pm_addr,
  output logic          pm_ack,
  output logic          pm_valid,
  input  logic          pf_req,
  input  logic [AW-1:0] pf_addr,
  output logic          pf_ack,
  output logic          pf_valid,
  output logic [DW-1:0] dma_rdata,
  output logic          halt,
  output logic          cpu_bus_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_we,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  logic          halt_q, halt_pm_q;
  logic          steal_q, steal_pm_q;
  logic          ret_q, ret_pm_q;
  logic [AW-1:0] grant_addr_q, steal_addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q       <= 1'b0;
      halt_pm_q    <= 1'b0;
      steal_q      <= 1'b0;
      steal_pm_q   <= 1'b0;
      ret_q        <= 1'b0;
      ret_pm_q     <= 1'b0;
      grant_addr_q <= '0;
      steal_addr_q <= '0;
      data_q       <= '0;
    end else begin
      halt_q       <= pm_req | pf_req;
      halt_pm_q    <= pm_req;
      grant_addr_q <= pm_req ? pm_addr : pf_addr;
      steal_q      <= halt_q;
      steal_pm_q   <= halt_pm_q;
      steal_addr_q <= grant_addr_q;
      ret_q        <= steal_q;
      ret_pm_q     <= steal_pm_q;
      if (steal_q) data_q <= mem_rdata;
    end
  end

  assign halt       = halt_q;
  assign pm_ack     = halt_q & halt_pm_q;
  assign pf_ack     = halt_q & ~halt_pm_q;
  assign cpu_bus_en = ~steal_q;
  assign mem_addr   = steal_q ? steal_addr_q : cpu_addr;
  assign mem_wdata  = cpu_wdata;
  assign mem_we     = cpu_we & ~steal_q;
  assign cpu_rdata  = mem_rdata;
  assign pm_valid   = ret_q & ret_pm_q;
  assign pf_valid   = ret_q & ~ret_pm_q;
  assign dma_rdata  = data_q;
endmodule

module dma_cycle_thief_chk (
  input logic clk,
  input logic rst_n,
  input logic pm_req,
  input logic pf_req,
  input logic pm_ack,
  input logic pf_ack,
  input logic pm_valid,
  input logic pf_valid,
  input logic halt,
  input logic cpu_bus_en,
  input logic mem_we
);
  assert_halt_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req || pf_req) |=> (halt && (pm_ack != pf_ack)));
  assert_pm_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req |=> (pm_ack && !pf_ack));
  assert_bus_floats_after_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!cpu_bus_en && !mem_we));
  assert_strobe_after_steal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_bus_en |=> $onehot({pm_valid, pf_valid}));
  assert_release_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pm_req || pf_req) |=> !halt);
  assert_cpu_owns_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> cpu_bus_en);
  assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cpu_bus_en) |=> !cpu_bus_en);
endmodule

bind dma_cycle_thief dma_cycle_thief_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pm_req(pm_req), .pf_req(pf_req),
  .pm_ack(pm_ack), .pf_ack(pf_ack), .pm_valid(pm_valid), .pf_valid(pf_valid),
  .halt(halt), .cpu_bus_en(cpu_bus_en), .mem_we(mem_we)
);

// File: tb/dma_cycle_thief_test.sv
module dma_cycle_thief_test;
  localparam int CLK_P = 10;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pm_req = 1'b0, pf_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] pm_addr = '0, pf_addr = '0, cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic pm_ack, pm_valid, pf_ack, pf_valid, halt, cpu_bus_en, mem_we;
  logic [DW-1:0] dma_rdata, cpu_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // decision history: 1 = latest edge, 2 = one before, 3 = two before
  bit d1_any = 0, d1_pm = 0, d2_any = 0, d2_pm = 0, d3_any = 0, d3_pm = 0;
  logic [AW-1:0] d1_addr = '0, d2_addr = '0, d3_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_fn(mem_addr);

  dma_cycle_thief #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .pm_req(pm_req), .pm_addr(pm_addr), .pm_ack(pm_ack), .pm_valid(pm_valid),
    .pf_req(pf_req), .pf_addr(pf_addr), .pf_ack(pf_ack), .pf_valid(pf_valid),
    .dma_rdata(dma_rdata), .halt(halt), .cpu_bus_en(cpu_bus_en),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_rdata(cpu_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R2 halt", 32'(halt), 32'(d1_any));
    chk("R2/R3 pm_ack", 32'(pm_ack), 32'(d1_any && d1_pm));
    chk("R2/R3 pf_ack", 32'(pf_ack), 32'(d1_any && !d1_pm));
    chk("R4/R6 cpu_bus_en", 32'(cpu_bus_en), 32'(!d2_any));
    if (d2_any) begin
      chk("R4 mem_addr", 32'(mem_addr), 32'(d2_addr));
      chk("R4 mem_we", 32'(mem_we), 32'd0);
    end else begin
      chk("R6 mem_addr", 32'(mem_addr), 32'(cpu_addr));
      chk("R6 mem_we", 32'(mem_we), 32'(cpu_we));
      chk("R6 mem_wdata", 32'(mem_wdata), 32'(cpu_wdata));
    end
    chk("R5 pm_valid", 32'(pm_valid), 32'(d3_any && d3_pm));
    chk("R5 pf_valid", 32'(pf_valid), 32'(d3_any && !d3_pm));
    if (d3_any) chk("R5/R7 dma_rdata", 32'(dma_rdata), 32'(mem_fn(d3_addr)));
    chk("R8 cpu_rdata", 32'(cpu_rdata), 32'(mem_rdata));
  endtask

  task automatic step(input bit pr, input bit fr, input logic [AW-1:0] pa,
                      input logic [AW-1:0] fa, input logic [AW-1:0] ca, input bit we);
    @(negedge clk);
    check_outputs();
    pm_req = pr; pf_req = fr; pm_addr = pa; pf_addr = fa;
    cpu_addr = ca; cpu_we = we; cpu_wdata = ca[7:0] ^ 8'hC3;
    d3_any = d2_any; d3_pm = d2_pm; d3_addr = d2_addr;
    d2_any = d1_any; d2_pm = d1_pm; d2_addr = d1_addr;
    d1_any = pr || fr; d1_pm = pr; d1_addr = pr ? pa : fa;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 halt in reset", 32'(halt), 32'd0);
    chk("R1 pm_ack in reset", 32'(pm_ack), 32'd0);
    chk("R1 pf_ack in reset", 32'(pf_ack), 32'd0);
    chk("R1 valids in reset", 32'({pm_valid, pf_valid}), 32'd0);
    chk("R1 bus_en in reset", 32'(cpu_bus_en), 32'd1);
    rst_n = 1'b1;
    // R6 idle processor traffic
    step(0, 0, 16'h0, 16'h0, 16'h1234, 1);
    step(0, 0, 16'h0, 16'h0, 16'h2345, 0);
    // R2 single playfield, R3 simultaneous, then release
    step(0, 1, 16'h0, 16'hA001, 16'h3000, 1);
    step(1, 1, 16'hB002, 16'hA003, 16'h3001, 1);
    step(0, 0, 16'h0, 16'h0, 16'h3002, 1);
    step(0, 0, 16'h0, 16'h0, 16'h3003, 0);
    step(0, 0, 16'h0, 16'h0, 16'h3004, 1);
    // R7 long back-to-back run alternating sources
    for (int i = 0; i < 12; i++)
      step(i[0], !i[0] || i[1], 16'hC000 + 16'(i), 16'hD000 + 16'(i), 16'h4000 + 16'(i), 1);
    // R3 both held for several cycles
    for (int i = 0; i < 4; i++)
      step(1, 1, 16'hE100 + 16'(i), 16'hF100 + 16'(i), 16'h5000, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0, 16'h0, 16'h6000 + 16'(i), i[0]);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step(r < 4, (r >= 2) && (r < 7), 16'($urandom), 16'($urandom),
           16'($urandom), 1'($urandom));
    end
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0, 16'h0, 16'h7000, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule